// File: doc/BRIEF.md
# Watch Time Character Formatter

This purely combinational block turns the decimal digits of a 12-hour watch into the eight-bit character codes that a two-line character LCD shows in its time row, "TIME:AM 12:07:25". Nine codes leave the block, one for each changing position: the meridiem letter and its trailing 'M', two hour digits, two minute digits, the seconds separator and two seconds digits. The fixed text around them ("TIME:", the space and the hour/minute colon) is produced by the display driver.

The mode controller supplies one-hot flags for power-up, meridiem edit, hour edit, minute-tens edit, minute-units edit and running time, and the blink generator supplies a phase bit. While the phase bit is low, the field that the current mode is editing turns into spaces. This makes the edited field flash on the display without any state in this block. A zero in the hour-tens position is always shown as a space, so single-digit hours are right-aligned.

Top module: `clock_field_formatter`

## Requirements
- R1: A digit d that is shown is output as code 8'h30 + d. This applies to hour units, both minute digits, both seconds digits, and to hour tens when it is 1 (8'h31).
- R2: A meridiem field that is shown outputs 8'h41 ('A') when the meridiem bit is 0 and 8'h50 ('P') when it is 1. The second position is always 8'h4D ('M').
- R3: When the hour-tens digit is 0, its position outputs 8'h20 (space) in every mode and at both blink phases.
- R4: When the blink phase is 1, no position is blanked by editing, whatever the mode flags are.
- R5: In the power-up mode with the blink phase at 0, both meridiem positions, both hour positions and both minute positions output 8'h20.
- R6: In meridiem edit with the blink phase at 0, only the two meridiem positions output 8'h20. Hours and minutes stay visible.
- R7: In hour edit with the blink phase at 0, only the two hour positions output 8'h20.
- R8: In minute-tens edit with the blink phase at 0, only the minute-tens position outputs 8'h20.
- R9: In minute-units edit with the blink phase at 0, only the minute-units position outputs 8'h20.
- R10: In running mode, no field is blanked at either blink phase.
- R11: The seconds separator is always 8'h3A (':'). The two seconds digits are always shown, in every mode and at both phases.
- R12: If several flags are set, power-up wins. Among the edit flags, the order of precedence is meridiem, hour, minute tens, minute units. With no flag set, nothing is blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_init | input | 1 | Power-up mode flag |
| mode_ampm | input | 1 | Meridiem edit mode flag |
| mode_hour | input | 1 | Hour edit mode flag |
| mode_mint | input | 1 | Minute-tens edit mode flag |
| mode_minu | input | 1 | Minute-units edit mode flag |
| mode_run | input | 1 | Running time mode flag |
| blink_on | input | 1 | Blink phase: 1 shows, 0 hides the edited field |
| pm | input | 1 | Meridiem bit, 0 = AM, 1 = PM |
| hr_tens | input | 1 | Hour tens digit |
| hr_units | input | 4 | Hour units digit |
| mn_tens | input | 3 | Minute tens digit |
| mn_units | input | 4 | Minute units digit |
| sc_tens | input | 3 | Seconds tens digit |
| sc_units | input | 4 | Seconds units digit |
| ch_ap | output | 8 | 'A'/'P' character code |
| ch_m | output | 8 | 'M' character code |
| ch_hr_t | output | 8 | Hour tens character code |
| ch_hr_u | output | 8 | Hour units character code |
| ch_mn_t | output | 8 | Minute tens character code |
| ch_mn_u | output | 8 | Minute units character code |
| ch_sc_sep | output | 8 | Seconds separator character code |
| ch_sc_t | output | 8 | Seconds tens character code |
| ch_sc_u | output | 8 | Seconds units character code |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the nine character codes. The bench changes the inputs on the falling clock edge and samples one nanosecond later, well before the next rising edge. No check therefore waits on a pipeline or races an edge. The bench sweeps nine flag patterns, both phases, both meridiems, every hour from 1 to 12 and every minute from 0 to 59.

// File: rtl/clock_field_pkg.sv
package clock_field_pkg;

    localparam int CHAR_W  = 8;
    localparam int DIGIT_W = 4;

    localparam logic [CHAR_W-1:0] CH_ZERO  = 8'h30;
    localparam logic [CHAR_W-1:0] CH_SPACE = 8'h20;
    localparam logic [CHAR_W-1:0] CH_COLON = 8'h3A;
    localparam logic [CHAR_W-1:0] CH_A     = 8'h41;
    localparam logic [CHAR_W-1:0] CH_P     = 8'h50;
    localparam logic [CHAR_W-1:0] CH_M     = 8'h4D;

    typedef enum logic [2:0] {
        EDIT_NONE,
        EDIT_ALL,
        EDIT_AMPM,
        EDIT_HOUR,
        EDIT_MINT,
        EDIT_MINU
    } edit_sel_e;

    typedef struct packed {
        logic ampm;
        logic hour;
        logic min_tens;
        logic min_units;
    } hide_t;

    typedef struct packed {
        logic init;
        logic ampm;
        logic hour;
        logic mint;
        logic minu;
        logic run;
    } mode_flags_t;

    function automatic logic [CHAR_W-1:0] digit_code(input logic [DIGIT_W-1:0] d);
        return CH_ZERO + {{(CHAR_W-DIGIT_W){1'b0}}, d};
    endfunction

endpackage

// File: rtl/clock_field_edit_decode.sv
module clock_field_edit_decode
    import clock_field_pkg::*;
(
    input  mode_flags_t flags,
    input  logic        blink_on,
    output hide_t       hide
);

    edit_sel_e sel;

    always_comb begin
        if (flags.init)      sel = EDIT_ALL;
        else if (flags.ampm) sel = EDIT_AMPM;
        else if (flags.hour) sel = EDIT_HOUR;
        else if (flags.mint) sel = EDIT_MINT;
        else if (flags.minu) sel = EDIT_MINU;
        else                 sel = EDIT_NONE;
    end

    always_comb begin
        hide = '0;
        if (!blink_on) begin
            unique case (sel)
                EDIT_ALL:  hide = '{ampm: 1'b1, hour: 1'b1, min_tens: 1'b1, min_units: 1'b1};
                EDIT_AMPM: hide.ampm      = 1'b1;
                EDIT_HOUR: hide.hour      = 1'b1;
                EDIT_MINT: hide.min_tens  = 1'b1;
                EDIT_MINU: hide.min_units = 1'b1;
                default:   hide = '0;
            endcase
        end
    end

endmodule

// File: rtl/clock_field_digit_char.sv
module clock_field_digit_char
    import clock_field_pkg::*;
#(
    parameter int W             = 4,
    parameter bit SUPPRESS_ZERO = 1'b0
) (
    input  logic [W-1:0]      digit,
    input  logic              blank,
    output logic [CHAR_W-1:0] code
);

    logic [DIGIT_W-1:0] wide;
    logic               zero_blank;

    assign wide = DIGIT_W'(digit);

    generate
        if (SUPPRESS_ZERO) begin : g_sup
            assign zero_blank = (digit == '0);
        end else begin : g_keep
            assign zero_blank = 1'b0;
        end
    endgenerate

    assign code = (blank || zero_blank) ? CH_SPACE : digit_code(wide);

endmodule

// File: rtl/clock_field_meridiem.sv
module clock_field_meridiem
    import clock_field_pkg::*;
(
    input  logic              pm,
    input  logic              blank,
    output logic [CHAR_W-1:0] code_letter,
    output logic [CHAR_W-1:0] code_m
);

    always_comb begin
        if (blank) begin
            code_letter = CH_SPACE;
            code_m      = CH_SPACE;
        end else begin
            code_letter = pm ? CH_P : CH_A;
            code_m      = CH_M;
        end
    end

endmodule

// File: rtl/clock_field_formatter.sv
module clock_field_formatter
    import clock_field_pkg::*;
(
    input  logic             mode_init,
    input  logic             mode_ampm,
    input  logic             mode_hour,
    input  logic             mode_mint,
    input  logic             mode_minu,
    input  logic             mode_run,
    input  logic             blink_on,
    input  logic             pm,
    input  logic             hr_tens,
    input  logic [3:0]       hr_units,
    input  logic [2:0]       mn_tens,
    input  logic [3:0]       mn_units,
    input  logic [2:0]       sc_tens,
    input  logic [3:0]       sc_units,
    output logic [7:0]       ch_ap,
    output logic [7:0]       ch_m,
    output logic [7:0]       ch_hr_t,
    output logic [7:0]       ch_hr_u,
    output logic [7:0]       ch_mn_t,
    output logic [7:0]       ch_mn_u,
    output logic [7:0]       ch_sc_sep,
    output logic [7:0]       ch_sc_t,
    output logic [7:0]       ch_sc_u
);

    mode_flags_t flags;
    hide_t       hide;

    assign flags = '{init: mode_init, ampm: mode_ampm, hour: mode_hour,
                     mint: mode_mint, minu: mode_minu, run: mode_run};

    clock_field_edit_decode u_decode (
        .flags    (flags),
        .blink_on (blink_on),
        .hide     (hide)
    );

    clock_field_meridiem u_merid (
        .pm          (pm),
        .blank       (hide.ampm),
        .code_letter (ch_ap),
        .code_m      (ch_m)
    );

    clock_field_digit_char #(.W(1), .SUPPRESS_ZERO(1'b1)) u_hr_t (
        .digit (hr_tens),  .blank (hide.hour),      .code (ch_hr_t));

    clock_field_digit_char #(.W(4)) u_hr_u (
        .digit (hr_units), .blank (hide.hour),      .code (ch_hr_u));

    clock_field_digit_char #(.W(3)) u_mn_t (
        .digit (mn_tens),  .blank (hide.min_tens),  .code (ch_mn_t));

    clock_field_digit_char #(.W(4)) u_mn_u (
        .digit (mn_units), .blank (hide.min_units), .code (ch_mn_u));

    clock_field_digit_char #(.W(3)) u_sc_t (
        .digit (sc_tens),  .blank (1'b0),           .code (ch_sc_t));

    clock_field_digit_char #(.W(4)) u_sc_u (
        .digit (sc_units), .blank (1'b0),           .code (ch_sc_u));

    assign ch_sc_sep = CH_COLON;

endmodule

// File: rtl/clock_field_formatter_chk.sv
module clock_field_formatter_chk (
    input logic       mode_init,
    input logic       mode_ampm,
    input logic       mode_hour,
    input logic       mode_mint,
    input logic       mode_minu,
    input logic       mode_run,
    input logic       blink_on,
    input logic       pm,
    input logic       hr_tens,
    input logic [3:0] hr_units,
    input logic [2:0] mn_tens,
    input logic [3:0] mn_units,
    input logic [2:0] sc_tens,
    input logic [3:0] sc_units,
    input logic [7:0] ch_ap,
    input logic [7:0] ch_m,
    input logic [7:0] ch_hr_t,
    input logic [7:0] ch_hr_u,
    input logic [7:0] ch_mn_t,
    input logic [7:0] ch_mn_u,
    input logic [7:0] ch_sc_sep,
    input logic [7:0] ch_sc_t,
    input logic [7:0] ch_sc_u
);

    logic known;

    assign known = !$isunknown({mode_init, mode_ampm, mode_hour, mode_mint, mode_minu,
                                mode_run, blink_on, pm, hr_tens, hr_units, mn_tens,
                                mn_units, sc_tens, sc_units, ch_ap, ch_m, ch_hr_t,
                                ch_hr_u, ch_mn_t, ch_mn_u, ch_sc_sep, ch_sc_t, ch_sc_u});

    always_comb begin
        if (known) begin
            a_r11_sep_colon: assert (ch_sc_sep == 8'h3A);
            a_r11_sec_shown: assert (ch_sc_t[7:4] == 4'h3 && ch_sc_u[7:4] == 4'h3);
            a_r3_hour_tens_blank: assert (hr_tens || ch_hr_t == 8'h20);
            a_r4_blink_shows_minutes: assert (!blink_on || (ch_mn_t != 8'h20 && ch_mn_u != 8'h20));
            a_r5_init_blanks: assert (!(mode_init && !blink_on) ||
                                      (ch_ap == 8'h20 && ch_m == 8'h20 && ch_hr_u == 8'h20 &&
                                       ch_mn_t == 8'h20 && ch_mn_u == 8'h20));
            a_r10_run_visible: assert (!(mode_run && !mode_init && !mode_ampm && !mode_hour &&
                                         !mode_mint && !mode_minu) ||
                                       (ch_m == 8'h4D && ch_hr_u != 8'h20));
            a_r2_m_letter: assert (ch_m == 8'h4D || ch_m == 8'h20);
        end
    end

endmodule

bind clock_field_formatter clock_field_formatter_chk u_chk (.*);

// File: tb/tb_clock_field_formatter.sv
module tb_clock_field_formatter;

    localparam time CLK_HALF = 2ns;

    logic clk = 1'b0;
    always #(CLK_HALF) clk = ~clk;

    logic       mode_init, mode_ampm, mode_hour, mode_mint, mode_minu, mode_run;
    logic       blink_on, pm, hr_tens;
    logic [3:0] hr_units, mn_units, sc_units;
    logic [2:0] mn_tens, sc_tens;
    logic [7:0] ch_ap, ch_m, ch_hr_t, ch_hr_u, ch_mn_t, ch_mn_u, ch_sc_sep, ch_sc_t, ch_sc_u;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    clock_field_formatter dut (.*);

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic set_flags(input int idx);
        logic [5:0] f;
        case (idx)
            0: f = 6'b100000;
            1: f = 6'b010000;
            2: f = 6'b001000;
            3: f = 6'b000100;
            4: f = 6'b000010;
            5: f = 6'b000001;
            6: f = 6'b000000;
            7: f = 6'b101000;
            default: f = 6'b010010;
        endcase
        {mode_init, mode_ampm, mode_hour, mode_mint, mode_minu, mode_run} = f;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Quiet state: all inputs zero, no mode flag set.
        {mode_init, mode_ampm, mode_hour, mode_mint, mode_minu, mode_run} = '0;
        {blink_on, pm, hr_tens} = '0;
        hr_units = '0; mn_tens = '0; mn_units = '0; sc_tens = '0; sc_units = '0;
        @(negedge clk); #1;
        chk("R12", "idle ap", ch_ap, 8'h41);
        chk("R3",  "idle hour tens", ch_hr_t, 8'h20);
        chk("R11", "idle sep", ch_sc_sep, 8'h3A);

        for (int mi = 0; mi < 9; mi++) begin
            for (int bl = 0; bl < 2; bl++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int h = 1; h <= 12; h++) begin
                        for (int m = 0; m < 60; m++) begin
                            bit hap, hhr, hmt, hmu;
                            int s;
                            string mt;
                            s = (h * 7 + m * 3) % 60;
                            @(negedge clk);
                            set_flags(mi);
                            blink_on = bl[0];
                            pm       = p[0];
                            hr_tens  = (h >= 10);
                            hr_units = 4'(h % 10);
                            mn_tens  = 3'(m / 10);
                            mn_units = 4'(m % 10);
                            sc_tens  = 3'(s / 10);
                            sc_units = 4'(s % 10);
                            #1;
                            // expected hidden fields while phase is low
                            {hap, hhr, hmt, hmu} = 4'b0000;
                            case (mi)
                                0, 7: {hap, hhr, hmt, hmu} = 4'b1111;
                                1, 8: hap = 1'b1;
                                2:    hhr = 1'b1;
                                3:    hmt = 1'b1;
                                4:    hmu = 1'b1;
                                default: ;
                            endcase
                            case (mi)
                                0: mt = "R5";
                                1: mt = "R6";
                                2: mt = "R7";
                                3: mt = "R8";
                                4: mt = "R9";
                                5: mt = "R10";
                                default: mt = "R12";
                            endcase
                            if (bl == 1) begin
                                {hap, hhr, hmt, hmu} = 4'b0000;
                                mt = "R4";
                            end
                            chk(hap ? mt : "R2", "ap", ch_ap,
                                hap ? 8'h20 : (p == 1 ? 8'h50 : 8'h41));
                            chk(hap ? mt : "R2", "m", ch_m, hap ? 8'h20 : 8'h4D);
                            chk(h < 10 ? "R3" : (hhr ? mt : "R1"), "hour tens", ch_hr_t,
                                (h < 10 || hhr) ? 8'h20 : 8'h31);
                            chk(hhr ? mt : "R1", "hour units", ch_hr_u,
                                hhr ? 8'h20 : 8'(48 + h % 10));
                            chk(hmt ? mt : "R1", "min tens", ch_mn_t,
                                hmt ? 8'h20 : 8'(48 + m / 10));
                            chk(hmu ? mt : "R1", "min units", ch_mn_u,
                                hmu ? 8'h20 : 8'(48 + m % 10));
                            chk("R11", "sec sep", ch_sc_sep, 8'h3A);
                            chk("R11", "sec tens", ch_sc_t, 8'(48 + s / 10));
                            chk("R11", "sec units", ch_sc_u, 8'(48 + s % 10));
                            if (mi != 5 && !(hap || hhr || hmt || hmu) && bl == 0) begin
                                // modes with nothing to hide at phase 0 (no flag)
                                chk("R12", "no-flag shown", ch_hr_u, 8'(48 + h % 10));
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule